// File: doc/BRIEF.md
# EPP Cycle Engine with Watchdog

This block runs enhanced-parallel-port cycles on a port it shares with the plain and bidirectional modes. When no cycle is running, the port's strobe, auto-feed and init lines and its data direction follow a small standard control register. A host request starts one address or data cycle. The engine asserts the matching strobe and keeps the host stalled (busy) while the peripheral holds its wait line low. It finishes the cycle on the first clock edge at which wait is seen high.

A watchdog counts clock cycles from the start of each cycle. If the peripheral still holds wait low when the limit is reached, the cycle is aborted. An aborted cycle releases its strobe at once, reports completion with an error, and sets a sticky time-out flag. The limit is derived from the clock frequency and the time-out length, both given as parameters. The default is 10 µs at 50 MHz, which is 500 cycles.

Top module: `epp_cycle_engine`

## Requirements
- R1: While idle, the pins follow the control register. `strobe_n` is the inverse of bit 0, `autofd_n` is the inverse of bit 1, and `init_n` equals bit 2. `pd_oe` is the inverse of bit 5, `write_n` equals bit 5, and `pd_out` shows `idle_data`. All control bits reset to 0.
- R2: A request accepted while idle raises `busy` on the next cycle. `busy` stays high while `wait_n` is low. `busy` drops after the first edge at which `wait_n` is high, and `done` pulses for one cycle at the same time.
- R3: During a cycle, `addrstb_n` is low for an address request (`req_addr`=1) and `datastb_n` is low for a data request. No strobe is low while idle. `strobe_n` and `autofd_n` are held high while busy.
- R4: The cycle direction is bit 5 of the control register, sampled at the start of the cycle. With bit 5 = 0 (write), `pd_oe`=1, `write_n`=0 and `pd_out`=`req_wdata`. With bit 5 = 1 (read), `pd_oe`=0 and `write_n`=1, and `rd_data` takes `pd_in` at the finishing edge.
- R5: The watchdog limit is LIMIT = CLK_MHZ × TIMEOUT_US cycles. If `wait_n` is low on the LIMIT-th cycle of the strobe, the cycle aborts after that edge: the strobe is released and `done` and `err` pulse. If `wait_n` is high on that same edge, the cycle completes normally.
- R6: An abort sets `tmo_flag`. The flag stays set until `sts_clr` is pulsed or the block is reset. If an abort and `sts_clr` fall on the same edge, the flag ends up set.
- R7: `err` is only ever high together with `done`. After an aborted cycle, a rejected request or a write, `rd_data` is 0. `rd_data` holds its value between `done` pulses.
- R8: A request made while any of control bits 0, 1 or 3 is 1 is rejected. The next cycle shows `done` and `err`, with no strobe and no change to `tmo_flag`.
- R9: Requests presented while `busy` is high are ignored.
- R10: Control writes made during a cycle change neither the cycle's direction nor its held lines. They take effect on the idle pins after the cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write value |
| sts_clr | input | 1 | Clears the time-out flag |
| req_valid | input | 1 | Cycle request, taken when not busy |
| req_addr | input | 1 | 1 = address cycle, 0 = data cycle |
| req_wdata | input | 8 | Byte to drive in a write cycle |
| idle_data | input | 8 | Byte driven on the port when idle |
| busy | output | 1 | Cycle in progress, host held |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Completion was an abort or a reject |
| rd_data | output | 8 | Byte captured by a read cycle |
| tmo_flag | output | 1 | Sticky time-out status |
| pd_out | output | 8 | Port data out |
| pd_oe | output | 1 | Port data output enable |
| pd_in | input | 8 | Port data in |
| wait_n | input | 1 | Peripheral wait, low stretches the cycle |
| write_n | output | 1 | Low for write direction |
| datastb_n | output | 1 | Data strobe |
| addrstb_n | output | 1 | Address strobe |
| strobe_n | output | 1 | Standard strobe line |
| autofd_n | output | 1 | Standard auto-feed line |
| init_n | output | 1 | Standard init line |

## Verification
Two pairs of events can land on the same edge. The first pair is normal completion and watchdog expiry: the peripheral model releases wait exactly on the last allowed strobe cycle, and the expected result is a clean completion with no flag. The second pair is the abort setting the flag and a software clear: the bench pulses `sts_clr` on the expiring edge, and the expected result is that the flag is set. A behavioural model in the bench predicts every output on every clock, so whichever event is given precedence shows up as a miscompare.

// File: rtl/epp_cycle_engine.sv
module epp_cycle_engine #(
  parameter int CLK_MHZ    = 50,
  parameter int TIMEOUT_US = 10,
  parameter int DW         = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [7:0]    ctl_wdata,
  input  logic          sts_clr,
  input  logic          req_valid,
  input  logic          req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] idle_data,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] rd_data,
  output logic          tmo_flag,
  output logic [DW-1:0] pd_out,
  output logic          pd_oe,
  input  logic [DW-1:0] pd_in,
  input  logic          wait_n,
  output logic          write_n,
  output logic          datastb_n,
  output logic          addrstb_n,
  output logic          strobe_n,
  output logic          autofd_n,
  output logic          init_n
);
  localparam int LIMIT = CLK_MHZ * TIMEOUT_US;
  localparam int CW    = $clog2(LIMIT + 1);

  logic c_stb, c_afd, c_init, c_sel, c_dir;
  logic cyc_rd, cyc_addr;
  logic [DW-1:0] cyc_wdata;
  logic [CW-1:0] cnt;
  logic unused_ctl;

  assign unused_ctl = ^{ctl_wdata[7:6], ctl_wdata[4]};

  wire ctl_bad = c_stb | c_afd | c_sel;
  wire take    = !busy && req_valid;
  wire start   = take && !ctl_bad;
  wire reject  = take && ctl_bad;
  wire finish  = busy && wait_n;
  wire expire  = busy && !wait_n && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {c_stb, c_afd, c_init, c_sel, c_dir} <= '0;
    end else if (ctl_we) begin
      {c_stb, c_afd, c_init, c_sel, c_dir} <=
        {ctl_wdata[0], ctl_wdata[1], ctl_wdata[2], ctl_wdata[3], ctl_wdata[5]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      cyc_rd    <= 1'b0;
      cyc_addr  <= 1'b0;
      cyc_wdata <= '0;
    end else if (start) begin
      busy      <= 1'b1;
      cnt       <= '0;
      cyc_rd    <= c_dir;
      cyc_addr  <= req_addr;
      cyc_wdata <= req_wdata;
    end else if (finish || expire) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done    <= 1'b0;
      err     <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= finish || expire || reject;
      err  <= (expire && !finish) || reject;
      if (finish)
        rd_data <= cyc_rd ? pd_in : '0;
      else if (expire || reject)
        rd_data <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       tmo_flag <= 1'b0;
    else if (expire)  tmo_flag <= 1'b1;
    else if (sts_clr) tmo_flag <= 1'b0;
  end

  assign pd_oe     = busy ? !cyc_rd : !c_dir;
  assign write_n   = !pd_oe;
  assign pd_out    = busy ? cyc_wdata : idle_data;
  assign datastb_n = !(busy && !cyc_addr);
  assign addrstb_n = !(busy && cyc_addr);
  assign strobe_n  = busy ? 1'b1 : !c_stb;
  assign autofd_n  = busy ? 1'b1 : !c_afd;
  assign init_n    = c_init;
endmodule

// File: rtl/epp_cycle_engine_chk.sv
module epp_cycle_engine_chk #(
  parameter int LIMIT = 500,
  parameter int DW    = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sts_clr,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic [DW-1:0] rd_data,
  input logic          tmo_flag,
  input logic          wait_n
);
  int runlen;
  always_ff @(posedge clk) begin
    if (!rst_n) runlen <= 0;
    else        runlen <= busy ? runlen + 1 : 0;
  end

  AST_WD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> runlen < LIMIT); // R5
  AST_WAIT_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !wait_n && runlen < LIMIT - 1 |=> busy); // R2
  AST_FINISH_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wait_n |=> !busy && done && !err); // R2
  AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_flag && !sts_clr |=> tmo_flag); // R6
  AST_TMO_WITH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> done && err); // R6
  AST_ERR_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done && rd_data == '0); // R7
endmodule

bind epp_cycle_engine epp_cycle_engine_chk #(.LIMIT(CLK_MHZ * TIMEOUT_US), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sts_clr(sts_clr), .busy(busy), .done(done),
  .err(err), .rd_data(rd_data), .tmo_flag(tmo_flag), .wait_n(wait_n)
);

// File: tb/test_epp_cycle_engine.sv
module test_epp_cycle_engine;
  localparam int LIMIT = 500;

  logic clk = 0;
  always #10 clk = ~clk;

  logic rst_n = 0, ctl_we = 0, sts_clr = 0, req_valid = 0, req_addr = 0, wait_n = 0;
  logic [7:0] ctl_wdata = 0, req_wdata = 0, idle_data = 8'h3C, pd_in = 0;
  logic busy, done, err, tmo_flag, pd_oe, write_n, datastb_n, addrstb_n, strobe_n, autofd_n, init_n;
  logic [7:0] rd_data, pd_out;

  epp_cycle_engine i_epp_cycle_engine (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .sts_clr(sts_clr),
    .req_valid(req_valid), .req_addr(req_addr), .req_wdata(req_wdata), .idle_data(idle_data),
    .busy(busy), .done(done), .err(err), .rd_data(rd_data), .tmo_flag(tmo_flag),
    .pd_out(pd_out), .pd_oe(pd_oe), .pd_in(pd_in), .wait_n(wait_n), .write_n(write_n),
    .datastb_n(datastb_n), .addrstb_n(addrstb_n), .strobe_n(strobe_n),
    .autofd_n(autofd_n), .init_n(init_n));

  int vectors = 0, miscompares = 0;
  string scen = "R1";

  bit m_busy, m_done, m_err, m_rd, m_addr, m_to, live;
  bit [7:0] m_wd, m_rdata, m_ctl;
  int m_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_err = 0; m_rd = 0; m_addr = 0; m_to = 0;
      m_wd = 0; m_rdata = 0; m_ctl = 0; m_cnt = 0;
    end else begin
      bit [7:0] old_ctl;
      old_ctl = m_ctl;
      m_done = 0; m_err = 0;
      if (ctl_we) m_ctl = ctl_wdata & 8'h2F;
      if (sts_clr) m_to = 0;
      if (!m_busy) begin
        if (req_valid) begin
          if (old_ctl[0] || old_ctl[1] || old_ctl[3]) begin
            m_done = 1; m_err = 1; m_rdata = 0;
          end else begin
            m_busy = 1; m_cnt = 0; m_rd = old_ctl[5]; m_addr = req_addr; m_wd = req_wdata;
          end
        end
      end else if (wait_n) begin
        m_busy = 0; m_done = 1; m_rdata = m_rd ? pd_in : 8'h00;
      end else if (m_cnt == LIMIT - 1) begin
        m_busy = 0; m_done = 1; m_err = 1; m_rdata = 0; m_to = 1;
      end else begin
        m_cnt++;
      end
    end
    live = 1;
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s/%s %s: actual %0h expected %0h", tag, scen, what, act, exp);
    end
  endtask

  always @(negedge clk) if (live) begin
    string pt;
    pt = m_busy ? "R3" : "R1";
    chk("R2", "busy", busy, m_busy);
    chk("R2", "done", done, m_done);
    chk("R7", "err", err, m_err);
    chk("R7", "rd_data", rd_data, m_rdata);
    chk("R6", "tmo_flag", tmo_flag, m_to);
    chk("R3", "datastb_n", datastb_n, !(m_busy && !m_addr));
    chk("R3", "addrstb_n", addrstb_n, !(m_busy && m_addr));
    chk(pt, "strobe_n", strobe_n, m_busy ? 1'b1 : !m_ctl[0]);
    chk(pt, "autofd_n", autofd_n, m_busy ? 1'b1 : !m_ctl[1]);
    chk("R1", "init_n", init_n, m_ctl[2]);
    chk("R4", "pd_oe", pd_oe, m_busy ? !m_rd : !m_ctl[5]);
    chk("R4", "write_n", write_n, m_busy ? m_rd : m_ctl[5]);
    chk("R4", "pd_out", pd_out, m_busy ? m_wd : idle_data);
  end

  int hold = 0, p_cnt = 0;
  bit clr_at_limit = 0;
  always @(posedge clk) begin
    #2;
    if (!datastb_n || !addrstb_n) begin
      wait_n = (p_cnt >= hold);
      if (clr_at_limit) sts_clr = (p_cnt == LIMIT - 1);
      p_cnt++;
    end else begin
      p_cnt = 0;
      wait_n = 0;
      if (clr_at_limit) sts_clr = 0;
    end
  end

  task automatic tick();
    @(posedge clk); #3;
  endtask

  task automatic wr_ctl(logic [7:0] v);
    ctl_we = 1; ctl_wdata = v; tick(); ctl_we = 0;
  endtask

  task automatic wait_done();
    for (int g = 0; g < LIMIT + 20 && !done; g++) tick();
    tick();
  endtask

  task automatic epp(logic a, int h, logic [7:0] wd, logic [7:0] pin);
    hold = h; pd_in = pin; req_addr = a; req_wdata = wd; req_valid = 1;
    tick(); req_valid = 0;
    wait_done();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL R2 watchdog: actual hung expected finished run");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    scen = "R1"; wr_ctl(8'h05); tick(); wr_ctl(8'h22); tick(); idle_data = 8'hC3; tick();
    scen = "R4"; wr_ctl(8'h00);
    epp(0, 0, 8'h5A, 8'h11);
    epp(1, 3, 8'hA7, 8'h22);
    scen = "R2"; epp(0, 9, 8'h01, 8'h33);
    scen = "R4"; wr_ctl(8'h24);
    epp(0, 4, 8'h00, 8'hA5);
    epp(1, 0, 8'h00, 8'h6E);
    scen = "R8"; wr_ctl(8'h21); epp(0, 0, 8'h00, 8'hFF);
    wr_ctl(8'h08); epp(1, 0, 8'h44, 8'hFF);
    wr_ctl(8'h02); epp(0, 0, 8'h44, 8'hFF);
    scen = "R9"; wr_ctl(8'h20);
    hold = 6; pd_in = 8'h9C; req_addr = 0; req_valid = 1; tick();
    req_addr = 1; tick(); tick(); req_valid = 0; wait_done();
    scen = "R10"; wr_ctl(8'h00);
    hold = 8; pd_in = 8'h00; req_addr = 1; req_wdata = 8'hE1; req_valid = 1; tick(); req_valid = 0;
    tick(); wr_ctl(8'h27); tick(); wait_done(); tick();
    scen = "R5"; wr_ctl(8'h20);
    epp(0, LIMIT, 8'h00, 8'h77);
    tick();
    scen = "R6"; epp(0, 1, 8'h00, 8'h12);
    sts_clr = 1; tick(); sts_clr = 0; tick();
    scen = "R5"; epp(1, LIMIT - 1, 8'h00, 8'h5D);
    scen = "R6"; clr_at_limit = 1; epp(0, LIMIT, 8'h00, 8'h00);
    clr_at_limit = 0; sts_clr = 0; tick();
    sts_clr = 1; tick(); sts_clr = 0; tick();
    scen = "R7"; wr_ctl(8'h00); epp(1, LIMIT + 5, 8'h3F, 8'h99);
    repeat (4) tick();
    rst_n = 0; tick(); rst_n = 1; scen = "R1"; tick(); tick();
    finish_run();
  end
endmodule